// File: doc/BRIEF.md
# Memory Reference Hold Interlock

This block decides, every cycle, whether the instruction currently presented by the processor must be held (re-executed next cycle) because the memory system cannot take its reference or cannot yet hand over read data. It looks at the instruction's reference kind, its task number and whether it reads the memory data register in immediate timing (operand bus) or deferred timing (register load). Against that it weighs per-task outstanding cache misses, the busy flag of the single store-data buffer shared by all tasks, a read-port conflict between immediate and deferred reads in consecutive cycles, and a short busy window in the address section that follows misses and storage-bound references.

The cache and storage datapaths sit outside. They report a miss alongside the reference (`ref_miss`), and they report each word loaded into a missing block (`fill_valid`, `fill_task`). An instruction is accepted when `hold` is low in its cycle. Only accepted instructions change state, and a held instruction is simply presented again. A task that is switched out keeps its miss tracking, and its fills keep counting while other tasks run.

Three state machines make up the block. Each task has a tracker with the states TT_IDLE and TT_FILL. TT_IDLE goes to TT_FILL on an accepted miss. TT_FILL returns to TT_IDLE on the last fill word. The address window has the states AW_IDLE, AW_MISS1 and AW_TAIL. AW_IDLE goes to AW_MISS1 after an accepted miss and to AW_TAIL after an accepted flush, map write, I/O read or I/O write. AW_MISS1 always goes to AW_TAIL, and AW_TAIL always goes to AW_IDLE. The read-port tracker has the states MP_QUIET and MP_BLOCK. It enters MP_BLOCK after an accepted fetch, long fetch, store or deferred read, and otherwise it enters MP_QUIET.

Top module: `mri_hold_interlock`

## Requirements
- R1: After reset, with no reference and no data read presented, `hold` and `addr_busy` are both 0.
- R2: Reference kind codes on `ref_kind` are: 0 none, 1 fetch, 2 long fetch, 3 store, 4 prefetch, 5 dummy, 6 flush, 7 map write, 8 I/O read, 9 I/O write. When a fetch, long fetch or store by task T is accepted with `ref_miss`=1, T's later fetch, long fetch, store and data reads are held until 16 fill words for T have been reported. The instruction after the 16th fill word is not held for this reason.
- R3: A miss outstanding for one task does not hold references or reads of another task.
- R4: While `dbuf_busy` is 1, a store or long fetch by any task is held. A plain fetch is not held by it.
- R5: An immediate data read (`md_rd`=1, `md_imm`=1) is held in the cycle after an accepted fetch, long fetch or store, and in the cycle after an accepted deferred read, even when the same task issued both.
- R6: A deferred data read (`md_imm`=0) in the cycle right after an accepted fetch that hit is not held.
- R7: `addr_busy` is 1 for the two cycles after an accepted fetch, long fetch, store or prefetch that missed, and for the one cycle after an accepted flush, map write, I/O read or I/O write.
- R8: `addr_busy` is also 1 whenever `dest_busy` is 1. While `addr_busy` is 1, any reference kind and any data read is held. A cycle with neither is not held.
- R9: Flush, map write and dummy references are not held by a miss outstanding for their own task.
- R10: A held instruction changes no state: a held reference flagged as a miss opens no address window and marks no miss outstanding.
- R11: An outstanding miss survives the task being switched out. Fill words for other tasks do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_kind | input | 4 | Reference kind of the current instruction (codes in R2) |
| cur_task | input | 4 | Task issuing the current instruction |
| md_rd | input | 1 | Current instruction reads the memory data register |
| md_imm | input | 1 | Read timing: 1 immediate, 0 deferred |
| ref_miss | input | 1 | Cache reports that the current reference misses |
| dbuf_busy | input | 1 | Shared store-data buffer still holds unpassed data |
| dest_busy | input | 1 | Destination of the pending reference cannot accept it |
| fill_valid | input | 1 | One word of a missing block was loaded this cycle |
| fill_task | input | 4 | Task whose block received the fill word |
| hold | output | 1 | Stall and retry the current instruction |
| addr_busy | output | 1 | Address section busy |

## Verification
The hardest situation to reach is the exact release point of a miss. That needs a block whose 15th word has arrived while the 16th has not, with a fill word for an unrelated task mixed into the stream. The stimulus issues a missing fetch and then lets another task run, and it also puts a flush of the missing task through its own address window. It then streams fill words one per cycle with no instruction presented. After the 15th fill word it presents a store of the missing task, which must be held. After the 16th it presents the same store again, which must go through. A second hard case is a held miss while `dest_busy` is raised, which shows that a held instruction leaves no trace.

// File: rtl/mri_pkg.sv
package mri_pkg;

    typedef enum logic [3:0] {
        RK_NONE     = 4'd0,
        RK_FETCH    = 4'd1,
        RK_LFETCH   = 4'd2,
        RK_STORE    = 4'd3,
        RK_PREFETCH = 4'd4,
        RK_DUMMY    = 4'd5,
        RK_FLUSH    = 4'd6,
        RK_MAPWR    = 4'd7,
        RK_IORD     = 4'd8,
        RK_IOWR     = 4'd9
    } ref_kind_e;

    typedef enum logic {
        TT_IDLE,
        TT_FILL
    } task_state_e;

    typedef enum logic [1:0] {
        AW_IDLE,
        AW_MISS1,
        AW_TAIL
    } win_state_e;

    typedef enum logic {
        MP_QUIET,
        MP_BLOCK
    } port_state_e;

    // fetch, long fetch or store: the kinds tracked for misses and read-port use
    function automatic logic kind_is_rw(input logic [3:0] k);
        return (k == RK_FETCH) || (k == RK_LFETCH) || (k == RK_STORE);
    endfunction

    // kinds that go straight to storage and occupy the address section one cycle
    function automatic logic kind_is_short(input logic [3:0] k);
        return (k == RK_FLUSH) || (k == RK_MAPWR) || (k == RK_IORD) || (k == RK_IOWR);
    endfunction

    function automatic logic kind_uses_dbuf(input logic [3:0] k);
        return (k == RK_STORE) || (k == RK_LFETCH);
    endfunction

    function automatic logic kind_is_ref(input logic [3:0] k);
        logic r;
        unique case (k)
            RK_FETCH, RK_LFETCH, RK_STORE, RK_PREFETCH,
            RK_DUMMY, RK_FLUSH, RK_MAPWR, RK_IORD, RK_IOWR: r = 1'b1;
            default:                                          r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mri_task_tracker.sv
module mri_task_tracker
    import mri_pkg::*;
#(
    parameter int BLOCK_WORDS = 16,
    localparam int CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fill,
    output logic pending
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_WORDS - 1);

    task_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TT_IDLE: begin
                if (start) begin
                    state_d = TT_FILL;
                    cnt_d   = '0;
                end
            end
            TT_FILL: begin
                if (start) begin
                    cnt_d = '0;
                end else if (fill) begin
                    if (cnt_q == LAST) begin
                        state_d = TT_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = TT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        pending = (state_q == TT_FILL);
    end

endmodule

// File: rtl/mri_addr_window.sv
module mri_addr_window
    import mri_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_long,
    input  logic open_short,
    output logic win_busy
);

    win_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AW_IDLE: begin
                if (open_long)       state_d = AW_MISS1;
                else if (open_short) state_d = AW_TAIL;
            end
            AW_MISS1: state_d = AW_TAIL;
            AW_TAIL:  state_d = AW_IDLE;
            default:  state_d = AW_IDLE;
        endcase
    end

    always_comb begin
        win_busy = (state_q != AW_IDLE);
    end

endmodule

// File: rtl/mri_md_port.sv
module mri_md_port
    import mri_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic occupy,
    output logic imm_blocked
);

    port_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MP_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MP_QUIET: state_d = occupy ? MP_BLOCK : MP_QUIET;
            MP_BLOCK: state_d = occupy ? MP_BLOCK : MP_QUIET;
            default:  state_d = MP_QUIET;
        endcase
    end

    always_comb begin
        imm_blocked = (state_q == MP_BLOCK);
    end

endmodule

// File: rtl/mri_hold_interlock.sv
module mri_hold_interlock
    import mri_pkg::*;
#(
    parameter int NUM_TASKS   = 16,
    parameter int BLOCK_WORDS = 16,
    localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ref_kind,
    input  logic [TASK_W-1:0] cur_task,
    input  logic              md_rd,
    input  logic              md_imm,
    input  logic              ref_miss,
    input  logic              dbuf_busy,
    input  logic              dest_busy,
    input  logic              fill_valid,
    input  logic [TASK_W-1:0] fill_task,
    output logic              hold,
    output logic              addr_busy
);

    logic [NUM_TASKS-1:0] pend;
    logic                 win_busy;
    logic                 imm_blocked;
    logic                 accepted;
    logic                 own_pend;
    logic                 miss_hold, dbuf_hold, imm_hold, busy_hold;
    logic                 is_ref, is_rw;

    always_comb begin
        is_ref   = kind_is_ref(ref_kind);
        is_rw    = kind_is_rw(ref_kind);
        own_pend = pend[cur_task];
    end

    generate
        for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
            logic st, fl;
            always_comb begin
                st = accepted && is_rw && ref_miss && (cur_task == TASK_W'(g));
                fl = fill_valid && (fill_task == TASK_W'(g));
            end
            mri_task_tracker #(.BLOCK_WORDS(BLOCK_WORDS)) trk_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .start   (st),
                .fill    (fl),
                .pending (pend[g])
            );
        end
    endgenerate

    logic open_long, open_short, port_occupy;

    always_comb begin
        open_long   = accepted && ref_miss && (is_rw || (ref_kind == RK_PREFETCH));
        open_short  = accepted && kind_is_short(ref_kind);
        port_occupy = accepted && (is_rw || (md_rd && !md_imm));
    end

    mri_addr_window win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_long  (open_long),
        .open_short (open_short),
        .win_busy   (win_busy)
    );

    mri_md_port port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .occupy      (port_occupy),
        .imm_blocked (imm_blocked)
    );

    always_comb begin
        addr_busy = win_busy || dest_busy;
        miss_hold = own_pend && (is_rw || md_rd);
        dbuf_hold = dbuf_busy && kind_uses_dbuf(ref_kind);
        imm_hold  = md_rd && md_imm && imm_blocked;
        busy_hold = addr_busy && (is_ref || md_rd);
        hold      = miss_hold || dbuf_hold || imm_hold || busy_hold;
        accepted  = !hold;
    end

endmodule

// File: rtl/mri_hold_checker.sv
module mri_hold_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ref_kind,
    input logic       md_rd,
    input logic       md_imm,
    input logic       ref_miss,
    input logic       dbuf_busy,
    input logic       hold,
    input logic       addr_busy
);

    logic rw_now, short_now;
    always_comb begin
        rw_now    = (ref_kind == 4'd1) || (ref_kind == 4'd2) || (ref_kind == 4'd3);
        short_now = (ref_kind == 4'd6) || (ref_kind == 4'd7) || (ref_kind == 4'd8) || (ref_kind == 4'd9);
    end

    AST_BUSY_HOLDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && (ref_kind != 4'd0 || md_rd)) |-> hold); // R8

    AST_QUIET_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_kind == 4'd0 && !md_rd) |-> !hold); // R8

    AST_MISS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && rw_now && ref_miss) |=> addr_busy ##1 addr_busy); // R7

    AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && short_now) |=> addr_busy); // R7

    AST_DBUF_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_busy && (ref_kind == 4'd3 || ref_kind == 4'd2)) |-> hold); // R4

    AST_IMM_AFTER_RW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hold && rw_now) && md_rd && md_imm) |-> hold); // R5

    AST_NO_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_kind == 4'd5 || ref_kind == 4'd6 || ref_kind == 4'd7) && !md_rd
         && !addr_busy) |-> !hold); // R9

endmodule

bind mri_hold_interlock mri_hold_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_kind  (ref_kind),
    .md_rd     (md_rd),
    .md_imm    (md_imm),
    .ref_miss  (ref_miss),
    .dbuf_busy (dbuf_busy),
    .hold      (hold),
    .addr_busy (addr_busy)
);

// File: tb/mri_hold_interlock_tb.sv
module mri_hold_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ref_kind = 4'd0;
    logic [3:0] cur_task = 4'd0;
    logic       md_rd = 1'b0;
    logic       md_imm = 1'b0;
    logic       ref_miss = 1'b0;
    logic       dbuf_busy = 1'b0;
    logic       dest_busy = 1'b0;
    logic       fill_valid = 1'b0;
    logic [3:0] fill_task = 4'd0;
    logic       hold;
    logic       addr_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mri_hold_interlock dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_kind   (ref_kind),
        .cur_task   (cur_task),
        .md_rd      (md_rd),
        .md_imm     (md_imm),
        .ref_miss   (ref_miss),
        .dbuf_busy  (dbuf_busy),
        .dest_busy  (dest_busy),
        .fill_valid (fill_valid),
        .fill_task  (fill_task),
        .hold       (hold),
        .addr_busy  (addr_busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input int k, input int t, input bit rd, input bit imm, input bit miss);
        ref_kind   = 4'(k);
        cur_task   = 4'(t);
        md_rd      = rd;
        md_imm     = imm;
        ref_miss   = miss;
        fill_valid = 1'b0;
        #1;
    endtask

    task automatic quiet();
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        quiet();
        check("R1 hold after reset", hold, 1'b0);
        check("R1 addr_busy after reset", addr_busy, 1'b0);
        tick();
    endtask

    task automatic t_miss_lifecycle();
        drive(1, 3, 0, 0, 1);
        check("R2 missing fetch accepted", hold, 1'b0);
        tick();
        quiet();
        check("R7 busy cycle 1 after miss", addr_busy, 1'b1);
        tick();
        quiet();
        check("R7 busy cycle 2 after miss", addr_busy, 1'b1);
        tick();
        quiet();
        check("R7 window closed after miss", addr_busy, 1'b0);
        tick();
        drive(1, 3, 0, 0, 0);
        check("R2 fetch of missing task held", hold, 1'b1);
        tick();
        drive(0, 3, 1, 0, 0);
        check("R2 read of missing task held", hold, 1'b1);
        tick();
        drive(1, 5, 0, 0, 0);
        check("R3 other task fetch not held", hold, 1'b0);
        tick();
        drive(6, 3, 0, 0, 0);
        check("R9 flush not held by own miss", hold, 1'b0);
        tick();
        drive(1, 5, 0, 0, 0);
        check("R8 fetch held in flush window", hold, 1'b1);
        check("R7 busy after flush", addr_busy, 1'b1);
        tick();
        quiet();
        fill_valid = 1'b1; fill_task = 4'd7;
        tick();
        for (int i = 0; i < 15; i++) begin
            quiet();
            fill_valid = 1'b1; fill_task = 4'd3;
            tick();
        end
        drive(3, 3, 0, 0, 0);
        check("R11 store held after 15 own fills", hold, 1'b1);
        tick();
        quiet();
        fill_valid = 1'b1; fill_task = 4'd3;
        tick();
        drive(3, 3, 0, 0, 0);
        check("R2 store released after 16th fill", hold, 1'b0);
        tick();
        quiet();
        tick();
    endtask

    task automatic t_held_no_effect();
        dest_busy = 1'b1;
        quiet();
        check("R8 dest_busy raises addr_busy", addr_busy, 1'b1);
        check("R8 empty cycle not held", hold, 1'b0);
        tick();
        drive(1, 2, 0, 0, 1);
        check("R8 fetch held while dest busy", hold, 1'b1);
        tick();
        dest_busy = 1'b0;
        quiet();
        check("R10 held miss opened no window", addr_busy, 1'b0);
        tick();
        drive(1, 2, 0, 0, 0);
        check("R10 held miss left no pending", hold, 1'b0);
        tick();
        quiet();
        tick();
    endtask

    task automatic t_store_buffer();
        dbuf_busy = 1'b1;
        drive(3, 1, 0, 0, 0);
        check("R4 store held on busy buffer", hold, 1'b1);
        tick();
        drive(2, 9, 0, 0, 0);
        check("R4 long fetch held on busy buffer", hold, 1'b1);
        tick();
        drive(1, 9, 0, 0, 0);
        check("R4 plain fetch not held", hold, 1'b0);
        tick();
        dbuf_busy = 1'b0;
        drive(3, 1, 0, 0, 0);
        check("R4 store accepted when buffer free", hold, 1'b0);
        tick();
        quiet();
        tick();
    endtask

    task automatic t_read_port();
        drive(1, 4, 0, 0, 0);
        check("R6 hit fetch accepted", hold, 1'b0);
        tick();
        drive(0, 4, 1, 0, 0);
        check("R6 deferred read after hit", hold, 1'b0);
        tick();
        drive(0, 6, 1, 1, 0);
        check("R5 immediate after deferred held", hold, 1'b1);
        tick();
        drive(0, 6, 1, 1, 0);
        check("R5 immediate retried goes", hold, 1'b0);
        tick();
        drive(1, 4, 0, 0, 0);
        tick();
        drive(0, 4, 1, 1, 0);
        check("R5 immediate after same-task fetch held", hold, 1'b1);
        tick();
        drive(0, 4, 1, 1, 0);
        check("R5 immediate one cycle later goes", hold, 1'b0);
        tick();
        quiet();
        tick();
    endtask

    task automatic t_storage_refs();
        drive(8, 8, 0, 0, 0);
        check("R7 io read accepted", hold, 1'b0);
        tick();
        quiet();
        check("R7 busy one cycle after io read", addr_busy, 1'b1);
        tick();
        quiet();
        check("R7 idle two cycles after io read", addr_busy, 1'b0);
        tick();
        drive(7, 0, 0, 0, 0);
        check("R7 map write accepted", hold, 1'b0);
        tick();
        drive(1, 0, 0, 0, 0);
        check("R8 fetch held after map write", hold, 1'b1);
        tick();
        quiet();
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_lifecycle();
        t_held_no_effect();
        t_store_buffer();
        t_read_port();
        t_storage_refs();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule